// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a 36-bit first-in first-out buffer that joins two unrelated clock domains. Words enter on the write port under `w_clk` and leave on the read port under `r_clk`. Either clock may run at any rate or phase relative to the other, including the same clock. A port moves a word on a rising edge of its own clock only when its active-low select is LOW and its enable is HIGH.

Each side drives two status pins, both built from pointers that were carried across the boundary as Gray code through two-flop synchronizers. The write side reports whether there is room and whether free space has dropped to the threshold `w_ofs_y`. The read side reports whether a word can be read and whether the stored count has dropped to the threshold `r_ofs_x`. Both threshold values come from offset registers that another block loads.

The read side has two timing modes, captured from `r_std_mode` while `r_rst` is HIGH. In standard mode a read request fetches the oldest word onto `r_data`. In fall-through mode the oldest word is placed on `r_data` without any request, and a request consumes it.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: A write takes place on a rising `w_clk` edge only when `w_sel_n` is LOW, `w_en` is HIGH and the buffer is not full. A cycle with `w_sel_n` HIGH or `w_en` LOW stores nothing.
- R2: `w_room` is LOW when DEPTH words are stored and HIGH otherwise, in both modes. A write attempted while `w_room` is LOW is dropped.
- R3: `w_room_lo_n` is LOW when the number of free locations (DEPTH minus stored words, as seen by the write side) is less than or equal to `w_ofs_y`, and HIGH otherwise.
- R4: `r_fill_lo_n` is LOW when the read side's word count is less than or equal to `r_ofs_x`, and HIGH otherwise. In fall-through mode that count includes the word held on `r_data`.
- R5: In standard mode, `r_avail` is HIGH when the buffer holds a word. A read request (`r_sel_n` LOW, `r_en` HIGH) puts the oldest word on `r_data` after that edge. A request while the buffer is empty leaves `r_data` and the contents unchanged.
- R6: In fall-through mode, the oldest word appears on `r_data` with `r_avail` HIGH without any request. A request consumes it, and `r_data` and `r_avail` hold while no request is made.
- R7: Words are read out in the order they were written, with no loss and no duplication, across the full depth.
- R8: A write becomes visible on the read-side flags after at least two and at most four rising `r_clk` edges, because pointers cross as Gray code through two synchronizer stages.
- R9: After reset, `w_room` is 1, `w_room_lo_n` is 1 (with `w_ofs_y` < DEPTH), `r_avail` is 0 and `r_fill_lo_n` is 0.
- R10: The mode is captured while `r_rst` is HIGH: 1 selects standard mode and 0 selects fall-through mode. Later changes of `r_std_mode` have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Write-side clock |
| w_rst | input | 1 | Synchronous active-high reset, write side |
| w_sel_n | input | 1 | Write port select, active LOW |
| w_en | input | 1 | Write port enable, active HIGH |
| w_data | input | WORD_W | Word to store |
| w_ofs_y | input | AW+1 | Free-space threshold for `w_room_lo_n` |
| w_room | output | 1 | HIGH: not full / ready for input |
| w_room_lo_n | output | 1 | LOW: free locations <= `w_ofs_y` |
| r_clk | input | 1 | Read-side clock |
| r_rst | input | 1 | Synchronous active-high reset, read side |
| r_std_mode | input | 1 | Mode captured during reset: 1 standard, 0 fall-through |
| r_sel_n | input | 1 | Read port select, active LOW |
| r_en | input | 1 | Read port enable, active HIGH |
| r_ofs_x | input | AW+1 | Fill threshold for `r_fill_lo_n` |
| r_data | output | WORD_W | Registered read word |
| r_avail | output | 1 | Standard: not empty; fall-through: valid word on `r_data` |
| r_fill_lo_n | output | 1 | LOW: stored words <= `r_ofs_x` |

## Verification
Some properties are checked by assertions on every edge of the owning clock: each side's view of the occupancy never exceeds the depth, a full or idle write port never moves its pointer, an empty standard-mode read never moves the read pointer, each Gray pointer changes at most one bit per edge, and a fall-through word with no request stays on `r_data`. Other behaviours only the directed scenarios can show. These are where the threshold flags switch at particular fill levels, word ordering across a full wrap, the latency of a write reaching the read flags, the values after reset, and the fact that the mode input is ignored after reset.

// File: rtl/dcff_pkg.sv
package dcff_pkg;
  typedef enum logic {RMODE_FALL = 1'b0, RMODE_STD = 1'b1} rmode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcff_sync.sv
module dcff_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/dcff_ram.sv
module dcff_ram #(
  parameter int WORD_W = 36,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcff_wr_ctrl.sv
module dcff_wr_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW:0]   ofs_y,
  input  logic [AW:0]   rgray_s,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          room,
  output logic          room_lo_n
);
  import dcff_pkg::*;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [AW:0] wbin, rbin_s, used, free_cnt, wbin_nx;
  logic [31:0] rb32, wg32;
  logic        full;

  assign rb32     = gray2bin(32'(rgray_s));
  assign rbin_s   = rb32[AW:0];
  assign used     = wbin - rbin_s;
  assign full     = (used == DEPTH_V);
  assign free_cnt = DEPTH_V - used;
  assign push     = req && !full;
  assign wbin_nx  = wbin + (AW+1)'(push);
  assign wg32     = bin2gray(32'(wbin_nx));
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wg32[AW:0];
    end
  end

  assign room      = !full;
  assign room_lo_n = !(free_cnt <= ofs_y);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    used <= DEPTH_V);
  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (!room && req) |=> $stable(wbin));
  p_idle_write_r1: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(wbin));
  p_gray_step_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcff_rd_ctrl.sv
module dcff_rd_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_in,
  input  logic          req,
  input  logic [AW:0]   ofs_x,
  input  logic [AW:0]   wgray_s,
  output logic          ram_re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          fall_mode,
  output logic          avail,
  output logic          fill_lo_n
);
  import dcff_pkg::*;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  rmode_e      mode_q;
  logic [AW:0] rbin, wbin_s, cnt, rbin_nx;
  logic [AW+1:0] words;
  logic [31:0] wb32, rg32;
  logic        nonempty, pop, out_valid;

  assign wb32     = gray2bin(32'(wgray_s));
  assign wbin_s   = wb32[AW:0];
  assign cnt      = wbin_s - rbin;
  assign nonempty = (cnt != '0);
  assign fall_mode = (mode_q == RMODE_FALL);

  always_comb begin
    if (fall_mode) pop = nonempty && (!out_valid || req);
    else           pop = nonempty && req;
  end

  assign rbin_nx = rbin + (AW+1)'(pop);
  assign rg32    = bin2gray(32'(rbin_nx));
  assign ram_re  = pop;
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= rmode_e'(mode_in);
      rbin      <= '0;
      rgray     <= '0;
      out_valid <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rg32[AW:0];
      if (fall_mode) begin
        if (pop)      out_valid <= 1'b1;
        else if (req) out_valid <= 1'b0;
      end
    end
  end

  assign words     = {1'b0, cnt} + (AW+2)'(out_valid);
  assign avail     = fall_mode ? out_valid : nonempty;
  assign fill_lo_n = !(words <= {1'b0, ofs_x});

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= DEPTH_V);
  p_empty_read_r5: assert property (@(posedge clk) disable iff (rst)
    (!fall_mode && !avail && req) |=> $stable(rbin));
  p_fall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (fall_mode && avail && !req) |=> avail);
  p_gray_step_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo #(
  parameter int WORD_W = 36,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              w_clk,
  input  logic              w_rst,
  input  logic              w_sel_n,
  input  logic              w_en,
  input  logic [WORD_W-1:0] w_data,
  input  logic [AW:0]       w_ofs_y,
  output logic              w_room,
  output logic              w_room_lo_n,
  input  logic              r_clk,
  input  logic              r_rst,
  input  logic              r_std_mode,
  input  logic              r_sel_n,
  input  logic              r_en,
  input  logic [AW:0]       r_ofs_x,
  output logic [WORD_W-1:0] r_data,
  output logic              r_avail,
  output logic              r_fill_lo_n
);
  logic          wr_req, rd_req, push, ram_re, fall_mode;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

  assign wr_req = !w_sel_n && w_en;
  assign rd_req = !r_sel_n && r_en;

  dcff_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(w_clk), .rst(w_rst), .req(wr_req), .ofs_y(w_ofs_y),
    .rgray_s(rgray_s), .push(push), .waddr(waddr), .wgray(wgray),
    .room(w_room), .room_lo_n(w_room_lo_n));

  dcff_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(r_clk), .rst(r_rst), .mode_in(r_std_mode), .req(rd_req),
    .ofs_x(r_ofs_x), .wgray_s(wgray_s), .ram_re(ram_re), .raddr(raddr),
    .rgray(rgray), .fall_mode(fall_mode), .avail(r_avail),
    .fill_lo_n(r_fill_lo_n));

  dcff_sync #(.W(AW+1)) u_w2r (
    .clk(r_clk), .rst(r_rst), .din(wgray), .dout(wgray_s));

  dcff_sync #(.W(AW+1)) u_r2w (
    .clk(w_clk), .rst(w_rst), .din(rgray), .dout(rgray_s));

  dcff_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .wclk(w_clk), .we(push), .waddr(waddr), .wdata(w_data),
    .rclk(r_clk), .re(ram_re), .raddr(raddr), .rdata(r_data));

  p_fall_data_hold_r6: assert property (@(posedge r_clk) disable iff (r_rst)
    (fall_mode && r_avail && !rd_req) |=> $stable(r_data));
endmodule

// File: tb/sim_dual_clk_flag_fifo.sv
module sim_dual_clk_flag_fifo;
  localparam int WORD_W = 36;
  localparam int DEPTH  = 16;
  localparam int AW     = $clog2(DEPTH);

  logic w_clk = 0, r_clk = 0;
  logic w_rst = 1, r_rst = 1;
  logic w_sel_n = 1, w_en = 0, r_sel_n = 1, r_en = 0, r_std_mode = 1;
  logic [WORD_W-1:0] w_data = '0;
  logic [AW:0] w_ofs_y = (AW+1)'(3);
  logic [AW:0] r_ofs_x = (AW+1)'(2);
  logic w_room, w_room_lo_n, r_avail, r_fill_lo_n;
  logic [WORD_W-1:0] r_data;

  int n_chk = 0, n_bad = 0;

  always #10 w_clk = ~w_clk;
  always #15 r_clk = ~r_clk;

  dual_clk_flag_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u0 (
    .w_clk(w_clk), .w_rst(w_rst), .w_sel_n(w_sel_n), .w_en(w_en),
    .w_data(w_data), .w_ofs_y(w_ofs_y), .w_room(w_room),
    .w_room_lo_n(w_room_lo_n), .r_clk(r_clk), .r_rst(r_rst),
    .r_std_mode(r_std_mode), .r_sel_n(r_sel_n), .r_en(r_en),
    .r_ofs_x(r_ofs_x), .r_data(r_data), .r_avail(r_avail),
    .r_fill_lo_n(r_fill_lo_n));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic std);
    r_std_mode = std;
    w_rst = 1; r_rst = 1;
    repeat (4) @(negedge r_clk);
    @(negedge w_clk) w_rst = 0;
    @(negedge r_clk) r_rst = 0;
    repeat (3) @(negedge r_clk);
  endtask

  task automatic wr(input logic [WORD_W-1:0] d, input logic sel_n = 0, input logic en = 1);
    @(negedge w_clk);
    w_data = d; w_sel_n = sel_n; w_en = en;
    @(negedge w_clk);
    w_sel_n = 1; w_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge r_clk);
    repeat (4) @(negedge w_clk);
  endtask

  task automatic rd_std(input logic [WORD_W-1:0] exp, input string tag);
    @(negedge r_clk);
    r_sel_n = 0; r_en = 1;
    @(negedge r_clk);
    r_sel_n = 1; r_en = 0;
    check(tag, 64'(r_data), 64'(exp));
  endtask

  task automatic pop_fall(input logic [WORD_W-1:0] exp, input string tag);
    @(negedge r_clk);
    check({tag, " avail"}, 64'(r_avail), 64'd1);
    check(tag, 64'(r_data), 64'(exp));
    r_sel_n = 0; r_en = 1;
    @(negedge r_clk);
    r_sel_n = 1; r_en = 0;
  endtask

  task automatic t_reset_state();
    do_reset(1);
    check("R9 w_room", 64'(w_room), 64'd1);
    check("R9 w_room_lo_n", 64'(w_room_lo_n), 64'd1);
    check("R9 r_avail", 64'(r_avail), 64'd0);
    check("R9 r_fill_lo_n", 64'(r_fill_lo_n), 64'd0);
  endtask

  task automatic t_standard_basic();
    do_reset(1);
    wr(36'h1_0000_0001, 1, 1);
    wr(36'h1_0000_0002, 0, 0);
    settle();
    check("R1 gated writes stored nothing", 64'(r_avail), 64'd0);
    wr(36'hA_1111_0000); wr(36'hA_1111_0001);
    settle();
    check("R5 avail when not empty", 64'(r_avail), 64'd1);
    check("R4 two words <= X", 64'(r_fill_lo_n), 64'd0);
    wr(36'hA_1111_0002);
    settle();
    check("R4 three words > X", 64'(r_fill_lo_n), 64'd1);
    rd_std(36'hA_1111_0000, "R7 order word0");
    rd_std(36'hA_1111_0001, "R7 order word1");
    rd_std(36'hA_1111_0002, "R7 order word2");
    settle();
    check("R5 empty after drain", 64'(r_avail), 64'd0);
    rd_std(36'hA_1111_0002, "R5 empty read leaves r_data");
  endtask

  task automatic t_fill_wrap();
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      wr(36'(36'hB_0000_0000 + i));
      if (i == 11) check("R3 free 4 > Y", 64'(w_room_lo_n), 64'd1);
      if (i == 12) check("R3 free 3 <= Y", 64'(w_room_lo_n), 64'd0);
      if (i == DEPTH-2) check("R2 room one short of full", 64'(w_room), 64'd1);
    end
    check("R2 full", 64'(w_room), 64'd0);
    wr(36'hF_FFFF_FFFF);
    settle();
    check("R2 still full after dropped write", 64'(w_room), 64'd0);
    for (int i = 0; i < DEPTH; i++)
      rd_std(36'(36'hB_0000_0000 + i), "R7 full-depth order");
    settle();
    check("R2 dropped word absent, empty", 64'(r_avail), 64'd0);
    check("R2 room after drain", 64'(w_room), 64'd1);
  endtask

  task automatic t_latency();
    settle();
    @(negedge w_clk);
    w_data = 36'hC_0000_0001; w_sel_n = 0; w_en = 1;
    @(posedge w_clk);
    #1;
    w_sel_n = 1; w_en = 0;
    check("R8 no flag right after write", 64'(r_avail), 64'd0);
    @(posedge r_clk); #1;
    check("R8 no flag after one r_clk edge", 64'(r_avail), 64'd0);
    repeat (3) @(posedge r_clk);
    #1;
    check("R8 flag within four r_clk edges", 64'(r_avail), 64'd1);
    rd_std(36'hC_0000_0001, "R8 word read");
  endtask

  task automatic t_fall_through();
    do_reset(0);
    check("R6 no word after reset", 64'(r_avail), 64'd0);
    wr(36'hD_0000_0000);
    settle();
    check("R6 word falls through", 64'(r_data), 64'hD_0000_0000);
    check("R6 avail without request", 64'(r_avail), 64'd1);
    check("R4 one word incl output <= X", 64'(r_fill_lo_n), 64'd0);
    wr(36'hD_0000_0001); wr(36'hD_0000_0002);
    settle();
    check("R4 output word counted", 64'(r_fill_lo_n), 64'd1);
    pop_fall(36'hD_0000_0000, "R6 pop0");
    pop_fall(36'hD_0000_0001, "R6 pop1");
    pop_fall(36'hD_0000_0002, "R6 pop2");
    @(negedge r_clk);
    check("R6 avail drops when drained", 64'(r_avail), 64'd0);
    check("R4 empty <= X", 64'(r_fill_lo_n), 64'd0);
  endtask

  task automatic t_mode_locked();
    do_reset(1);
    r_std_mode = 0;
    wr(36'hE_0000_00AA);
    settle();
    rd_std(36'hE_0000_00AA, "R10 read after mode pin flip");
    wr(36'hE_0000_00BB);
    settle();
    check("R10 still standard: no fall-through", 64'(r_data), 64'hE_0000_00AA);
    check("R10 avail means not empty", 64'(r_avail), 64'd1);
    rd_std(36'hE_0000_00BB, "R10 second word");
  endtask

  initial begin
    repeat (100000) @(posedge w_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_standard_basic();
    t_fill_wrap();
    t_latency();
    t_fall_through();
    t_mode_locked();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule